// File: doc/BRIEF.md
# Serial Clock-Configuration Write Port

This block is the configuration side of a clock generator. It listens on a two-wire serial bus made of a clock line and a data line, and it samples both lines through synchronizers on the system clock. It responds only to its own fixed 7-bit device address when the transfer is a write. It acknowledges the address and every data byte by pulling the data line low. The bytes that follow the address fill a small bank of configuration registers in order, starting at byte zero.

The register bank drives a 2-bit operating-mode field. It also drives an enable vector for each group of clock outputs: CPU clocks, USB clock, PCI clocks, free-running PCI clock, AGP clocks, SDRAM clocks and the reference clock. Every enable comes out of reset set to active. The system around the block uses these outputs to gate the clock drivers or to place them in a test or three-state mode. Nothing can be read back through this port.

The open-drain data driver appears here as a single drive-low enable. A STOP ends the transfer, and so does a repeated START. In both cases the registers keep whatever full bytes have already arrived.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: After reset the mode field is 00, every clock enable output is 1, and the data line is released (drive-low enable is 0).
- R2: After a START, the address byte 1101001 followed by a R/W bit of 0 (byte value 0xD2, sent MSB first) is acknowledged: the drive-low enable is 1 while the bus clock is high for the ninth pulse.
- R3: An address byte with any other 7-bit address is not acknowledged, and the data bytes that follow it leave every output unchanged until the next START.
- R4: The correct address with R/W bit 1 (0xD3) is not acknowledged, and the bytes that follow it leave every output unchanged.
- R5: Data bits arrive MSB first. Bits 1:0 of byte 0 set the mode output: 00 normal, 01 test, 11 three-state. The value 10 is stored as received.
- R6: Bits 3:0 of byte 1 set CPU enables 3..0, and bit 7 of byte 1 sets the USB enable (1 = active).
- R7: Bits 3:0 of byte 2 set PCI enables 3..0. Bit 4 sets AGP enable 0, bit 5 sets AGP enable 1, and bit 6 sets the free-running PCI enable.
- R8: Byte 3 bits 7:0 set SDRAM enables 7..0, and byte 4 bits 3:0 set SDRAM enables 11..8.
- R9: Bit 0 of byte 5 sets the reference enable. Byte 6, and any byte after byte 6, changes no output.
- R10: Every data byte after an acknowledged address is acknowledged in its ninth clock, including bytes past byte 6.
- R11: A STOP or a repeated START ends the transfer. Full bytes already received are kept and a partially shifted byte is discarded. After a repeated START with a matching address, writing starts again at byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_drive_low_o | output | 1 | 1 pulls the data line low (acknowledge) |
| mode_o | output | 2 | Operating mode field |
| cpu_en_o | output | 4 | CPU clock enables |
| usb_en_o | output | 1 | USB clock enable |
| pci_en_o | output | 4 | PCI clock enables |
| agp_en_o | output | 2 | AGP clock enables |
| pcif_en_o | output | 1 | Free-running PCI clock enable |
| sdram_en_o | output | 12 | SDRAM clock enables |
| ref_en_o | output | 1 | Reference clock enable |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, device address 0x69 and a bank of seven bytes. With these values the real address and read/write codes can be used, and byte 6 plus two extra bytes can be sent to reach the end-of-bank limit. The bus is driven with a quarter-period of ten system clocks. That leaves room for the synchronizer delay before the acknowledge is sampled, while the synchronizer delay stays short enough to matter. A repeated START sent in the middle of a byte tests both the discarding of the partial byte and the restart at byte 0.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_ADDR,
    RX_ADDR_ACK,
    RX_DATA,
    RX_DATA_ACK
  } rx_state_e;

  // Address byte accepted only as a write to our own device address.
  function automatic logic addr_hit(input logic [7:0] rx_byte, input logic [6:0] dev_addr);
    return rx_byte == {dev_addr, 1'b0};
  endfunction

  // Next byte slot, held at the limit once the bank is full.
  function automatic int unsigned next_slot(input int unsigned slot, input int unsigned limit);
    return (slot >= limit) ? limit : slot + 1;
  endfunction

endpackage

// File: rtl/clkcfg_line_sync.sv
module clkcfg_line_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '1;
      else if (s == 0) chain[s] <= d_i;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/clkcfg_rx.sv
module clkcfg_rx
  import clkcfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h69,
  parameter int         NUM_BYTES = 7,
  localparam int        IDX_W     = $clog2(NUM_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_s,
  input  logic             sda_s,
  output logic             sda_drive_low,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data
);
  rx_state_e        state;
  logic             scl_q, sda_q;
  logic [7:0]       shreg;
  logic [3:0]       bitcnt;
  logic [IDX_W-1:0] slot;

  // Named bus events for the assertions below.
  logic start_evt, stop_evt, scl_rise, scl_fall;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= RX_IDLE;
      shreg         <= '0;
      bitcnt        <= '0;
      slot          <= '0;
      sda_drive_low <= 1'b0;
      wr_en         <= 1'b0;
      wr_idx        <= '0;
      wr_data       <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_evt) begin
        state         <= RX_ADDR;
        bitcnt        <= '0;
        slot          <= '0;
        sda_drive_low <= 1'b0;
      end else if (stop_evt) begin
        state         <= RX_IDLE;
        sda_drive_low <= 1'b0;
      end else begin
        unique case (state)
          RX_ADDR, RX_DATA: begin
            if (scl_rise && bitcnt < 4'd8) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              if (state == RX_ADDR) begin
                if (addr_hit(shreg, DEV_ADDR)) begin
                  sda_drive_low <= 1'b1;
                  state         <= RX_ADDR_ACK;
                end else begin
                  state <= RX_IDLE;
                end
              end else begin
                sda_drive_low <= 1'b1;
                state         <= RX_DATA_ACK;
                wr_en         <= (int'(slot) < NUM_BYTES);
                wr_idx        <= slot;
                wr_data       <= shreg;
                slot          <= IDX_W'(next_slot(int'(slot), NUM_BYTES));
              end
            end
          end
          RX_ADDR_ACK, RX_DATA_ACK: begin
            if (scl_fall) begin
              sda_drive_low <= 1'b0;
              state         <= RX_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r2_ack_in_ack_phase: assert property (@(posedge clk) disable iff (!rst_n)
    sda_drive_low |-> (state == RX_ADDR_ACK || state == RX_DATA_ACK));
  a_r10_ack_begins_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_low) |-> !scl_s);
  a_r11_stop_releases_sda: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_drive_low);
  a_r9_write_within_bank: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_idx) < NUM_BYTES));
  a_r5_bitcnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= 4'd8);
endmodule

// File: rtl/clkcfg_regbank.sv
module clkcfg_regbank #(
  parameter int  NUM_BYTES = 7,
  localparam int IDX_W     = $clog2(NUM_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  output logic [1:0]       mode,
  output logic [3:0]       cpu_en,
  output logic             usb_en,
  output logic [3:0]       pci_en,
  output logic [1:0]       agp_en,
  output logic             pcif_en,
  output logic [11:0]      sdram_en,
  output logic             ref_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= 2'b00;
      cpu_en   <= '1;
      usb_en   <= 1'b1;
      pci_en   <= '1;
      agp_en   <= '1;
      pcif_en  <= 1'b1;
      sdram_en <= '1;
      ref_en   <= 1'b1;
    end else if (wr_en) begin
      case (wr_idx)
        IDX_W'(0): mode <= wr_data[1:0];
        IDX_W'(1): begin
          cpu_en <= wr_data[3:0];
          usb_en <= wr_data[7];
        end
        IDX_W'(2): begin
          pci_en  <= wr_data[3:0];
          agp_en  <= wr_data[5:4];
          pcif_en <= wr_data[6];
        end
        IDX_W'(3): sdram_en[7:0]  <= wr_data;
        IDX_W'(4): sdram_en[11:8] <= wr_data[3:0];
        IDX_W'(5): ref_en <= wr_data[0];
        default: ;
      endcase
    end
  end

  logic [26:0] cfg_flat;
  assign cfg_flat = {mode, cpu_en, usb_en, pci_en, agp_en, pcif_en, sdram_en, ref_en};

  a_r1_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_flat));
  a_r9_reserved_slot_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_idx) >= 6) |=> $stable(cfg_flat));
  a_r8_sdram_split: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IDX_W'(3)) |=> $stable(sdram_en[11:8]));
endmodule

// File: rtl/clkcfg_i2c_slave.sv
module clkcfg_i2c_slave #(
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         NUM_BYTES   = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_drive_low_o,
  output logic [1:0]  mode_o,
  output logic [3:0]  cpu_en_o,
  output logic        usb_en_o,
  output logic [3:0]  pci_en_o,
  output logic [1:0]  agp_en_o,
  output logic        pcif_en_o,
  output logic [11:0] sdram_en_o,
  output logic        ref_en_o
);
  localparam int IDX_W = $clog2(NUM_BYTES + 1);

  logic [1:0]       bus_s;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_data;

  clkcfg_line_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}), .q_o(bus_s)
  );

  clkcfg_rx #(.DEV_ADDR(DEV_ADDR), .NUM_BYTES(NUM_BYTES)) u_rx (
    .clk(clk), .rst_n(rst_n), .scl_s(bus_s[1]), .sda_s(bus_s[0]),
    .sda_drive_low(sda_drive_low_o), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  clkcfg_regbank #(.NUM_BYTES(NUM_BYTES)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .mode(mode_o), .cpu_en(cpu_en_o), .usb_en(usb_en_o), .pci_en(pci_en_o),
    .agp_en(agp_en_o), .pcif_en(pcif_en_o), .sdram_en(sdram_en_o), .ref_en(ref_en_o)
  );
endmodule

// File: tb/clkcfg_i2c_slave_tb.sv
module clkcfg_i2c_slave_tb;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_drive_low;
  logic sda_line;
  logic [1:0] mode;
  logic [3:0] cpu_en, pci_en;
  logic usb_en, pcif_en, ref_en;
  logic [1:0] agp_en;
  logic [11:0] sdram_en;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_drive_low;

  clkcfg_i2c_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_drive_low_o(sda_drive_low), .mode_o(mode), .cpu_en_o(cpu_en),
    .usb_en_o(usb_en), .pci_en_o(pci_en), .agp_en_o(agp_en), .pcif_en_o(pcif_en),
    .sdram_en_o(sdram_en), .ref_en_o(ref_en)
  );

  // Bench model of the expected register state.
  logic [1:0] m_mode; logic [3:0] m_cpu, m_pci; logic m_usb, m_pcif, m_ref;
  logic [1:0] m_agp; logic [11:0] m_sdram;

  task automatic model_reset();
    m_mode = 2'b00; m_cpu = 4'hF; m_usb = 1; m_pci = 4'hF; m_agp = 2'b11;
    m_pcif = 1; m_sdram = 12'hFFF; m_ref = 1;
  endtask

  task automatic model_byte(input int idx, input logic [7:0] v);
    case (idx)
      0: m_mode = {v[1], v[0]};
      1: begin m_cpu = v[3:0]; m_usb = v[7]; end
      2: begin m_pci = v[3:0]; m_agp[0] = v[4]; m_agp[1] = v[5]; m_pcif = v[6]; end
      3: m_sdram[7:0] = v;
      4: m_sdram[11:8] = v[3:0];
      5: m_ref = v[0];
      default: ;
    endcase
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_outputs(input string ctx);
    check({"R5 mode ", ctx}, 32'(mode), 32'(m_mode));
    check({"R6 cpu/usb ", ctx}, 32'({cpu_en, usb_en}), 32'({m_cpu, m_usb}));
    check({"R7 pci/agp/pcif ", ctx}, 32'({pci_en, agp_en, pcif_en}), 32'({m_pci, m_agp, m_pcif}));
    check({"R8 sdram ", ctx}, 32'(sdram_en), 32'(m_sdram));
    check({"R9 ref ", ctx}, 32'(ref_en), 32'(m_ref));
  endtask

  task automatic wq(); repeat (Q) @(posedge clk); #1; endtask

  task automatic bus_start();
    sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq(); wq();
  endtask

  task automatic send_bits(input int n, input logic [7:0] v);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = v[i]; wq(); scl_m = 1; wq(); wq(); scl_m = 0; wq();
    end
  endtask

  task automatic send_byte(input logic [7:0] v, output bit acked);
    send_bits(8, v);
    sda_m = 1; wq(); scl_m = 1; wq();
    acked = (sda_line == 1'b0);
    wq(); scl_m = 0; wq();
  endtask

  // Table: byte k of each write lives in bits [8k+7:8k].
  localparam logic [55:0] VEC [6] = '{
    56'h00_00_00_00_00_00_00,
    56'hFF_01_0F_FF_7F_8F_03,
    56'h00_00_05_A5_2A_85_01,
    56'h00_01_0A_5A_55_0A_02,
    56'hFF_00_03_3C_40_80_00,
    56'h00_01_0C_C3_15_03_03
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit ak;
    model_reset();
    repeat (5) @(posedge clk); #1;
    rst_n = 1;
    wq();
    // R1 reset state
    check("R1 sda released", 32'(sda_drive_low), 0);
    check_outputs("R1 after reset");

    for (int v = 0; v < 6; v++) begin
      bus_start();
      send_byte(8'hD2, ak);
      check("R2 address ack", 32'(ak), 1);
      for (int k = 0; k < 7; k++) begin
        send_byte(VEC[v][8*k +: 8], ak);
        check("R10 data ack", 32'(ak), 1);
        model_byte(k, VEC[v][8*k +: 8]);
      end
      bus_stop();
      check_outputs($sformatf("vector %0d", v));
    end

    // R3 wrong address ignored
    bus_start();
    send_byte(8'hA4, ak);
    check("R3 wrong address nack", 32'(ak), 0);
    send_byte(8'h00, ak);
    send_byte(8'h00, ak);
    bus_stop();
    check_outputs("R3 after wrong address");

    // R4 read request ignored
    bus_start();
    send_byte(8'hD3, ak);
    check("R4 read request nack", 32'(ak), 0);
    send_byte(8'h01, ak);
    send_byte(8'h00, ak);
    bus_stop();
    check_outputs("R4 after read request");

    // R9/R10 writes past the bank are acked and discarded
    bus_start();
    send_byte(8'hD2, ak);
    for (int k = 0; k < 9; k++) begin
      logic [7:0] b;
      b = (k < 7) ? VEC[1][8*k +: 8] : 8'h00;
      send_byte(b, ak);
      check($sformatf("R10 ack byte %0d", k), 32'(ak), 1);
      model_byte(k, b);
    end
    bus_stop();
    check_outputs("R9 overflow");

    // R11 partial transfer keeps received bytes
    bus_start();
    send_byte(8'hD2, ak);
    send_byte(8'h01, ak); model_byte(0, 8'h01);
    send_byte(8'h00, ak); model_byte(1, 8'h00);
    bus_stop();
    check_outputs("R11 stop after two bytes");

    // R11 repeated start mid-byte: partial byte discarded, restart at byte 0
    bus_start();
    send_byte(8'hD2, ak);
    send_byte(8'h03, ak); model_byte(0, 8'h03);
    send_bits(4, 8'hA0);
    bus_start();
    send_byte(8'hD2, ak);
    check("R11 ack after repeated start", 32'(ak), 1);
    send_byte(8'h00, ak); model_byte(0, 8'h00);
    send_byte(8'h8F, ak); model_byte(1, 8'h8F);
    bus_stop();
    check_outputs("R11 repeated start");

    // R1 reset again restores defaults
    rst_n = 0; wq(); rst_n = 1; wq();
    model_reset();
    check("R1 sda released after reset", 32'(sda_drive_low), 0);
    check_outputs("R1 second reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule